// File: doc/BRIEF.md
# Deadline-Bounded Span Fill Writer

This block paints horizontal spans of one colour into an SDRAM framebuffer during the vertical blanking gap. A drawing engine queues span records (start column, line number, pixel count, colour and a repeating transparency pattern). The block turns each record into one burst write. The colour is put on the data bus once and held for the whole burst. The per-pixel byte mask pulls out the pixels that must stay untouched, for glyph-style drawing.

A scanout controller opens a write window with a grant and a clock budget. The block counts that budget down. It accepts a record only when the whole span, including row open and close, fits in the clocks left. Once a record does not fit, it stops taking records, waits for the budget to run out, and then signals that the bus may be taken back. The SDRAM row is the display line plus a page base, and the starting column is the span's x position.

Top module: `span_fill_writer`

## Requirements
- R1: `rec_ready` is low whenever `win_grant` is low. A rising grant, seen in the idle state, loads `win_clocks` as the remaining budget on that clock edge.
- R2: After a record is taken at edge h, the outputs after edge h+k follow this schedule, with W the width. At k=0 the command is ACTIVE with `sd_addr` = row and `sd_bank` = bank. At k=TRCD it is WRITE with `sd_addr` = x. At k=TRCD+W it is BURST TERMINATE. At k=TRCD+W+TWR it is PRECHARGE. Every other cycle up to k=TRCD+W+TWR+TRP+1 is NOP. The line is L = (page_base + y) mod 2^(ROWW+BW); the row is L[ROWW-1:0] and the bank is L[ROWW+BW-1:ROWW]. The 3-bit `sd_cmd` code {ras_n,cas_n,we_n} is NOP 111, ACTIVE 011, WRITE 100, BURST TERMINATE 110, PRECHARGE 010.
- R3: `sd_dq_oe` is high for exactly the W cycles k=TRCD..TRCD+W-1, and `sd_dq` equals the record colour, unchanged, throughout them.
- R4: For the pixel at burst cycle i (k=TRCD+i), `sd_dqm` equals `rec_skip[i mod MW]`.
- R5: A one-pixel span gives WRITE at k=TRCD and BURST TERMINATE at k=TRCD+1, with the data enable high for one cycle.
- R6: A zero-width record is taken in one cycle, issues no command, and the block can take the next record on the following edge.
- R7: A record of width W>0 is taken only if TRCD+W+TWR+TRP+2 is no more than the remaining budget at the handshake edge. A zero-width record needs a non-zero budget.
- R8: After a record is refused for lack of budget, no further record is taken. `win_done` rises one edge after the budget reaches zero, i.e. W+1 edges after the load edge for a window of W clocks. It then stays high with NOP commands until the grant falls.
- R9: While a span is in progress, `rec_ready` stays low. The next record can be taken exactly cost cycles after the previous handshake.
- R10: During and after reset, `rec_ready`, `win_done` and `sd_dq_oe` are low and `sd_cmd` is NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_grant | input | 1 | Write window granted by scanout control |
| win_clocks | input | CW | Window length in clocks, loaded when the grant rises |
| win_done | output | 1 | Budget spent, bus may be taken back |
| page_base | input | ROWW+BW | Line offset of the frame page being painted |
| rec_valid | input | 1 | Span record present |
| rec_ready | output | 1 | Span record taken this cycle when high with valid |
| rec_x | input | XW | Starting column |
| rec_y | input | YW | Display line |
| rec_width | input | XW+1 | Span length in pixels |
| rec_color | input | DW | Fill value |
| rec_skip | input | MW | Repeating per-pixel mask pattern |
| sd_cmd | output | 3 | {ras_n,cas_n,we_n} command |
| sd_addr | output | ROWW | Row or column address |
| sd_bank | output | BW | Bank select |
| sd_dqm | output | 1 | Byte mask for the current pixel |
| sd_dq | output | DW | Write data |
| sd_dq_oe | output | 1 | Data bus drive enable |

## Verification
Every SDRAM output is registered. The ACTIVE for a record taken at edge h is visible just after edge h. The WRITE and the first pixel follow TRCD edges later, the terminate W edges after that, the precharge TWR later, and the next handshake is possible at edge h plus cost. The bench drives and samples on the falling edge. Right after the handshake edge it walks the span offset by offset, comparing command, address, data, mask and ready at each step. The budget is checked at its exact boundary, where cost equals the remaining count and one pixel more is refused. The done flag is checked at the exact edge count after the window load.

// File: rtl/span_fill_pkg.sv
package span_fill_pkg;
  // SDRAM command code as {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_ACT   = 3'b011,
    CMD_WRITE = 3'b100,
    CMD_BST   = 3'b110,
    CMD_PRE   = 3'b010,
    CMD_NOP   = 3'b111
  } sd_cmd_e;

  typedef enum logic [1:0] {
    WS_OFF,
    WS_OPEN,
    WS_DRAIN,
    WS_DONE
  } win_state_e;
endpackage

// File: rtl/span_fill_budget.sv
module span_fill_budget #(
  parameter int CW   = 16,
  parameter int WW   = 11,
  parameter int TRCD = 2,
  parameter int TWR  = 2,
  parameter int TRP  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  input  logic [WW-1:0] span_w,
  output logic          fits,
  output logic          expired
);
  localparam logic [CW-1:0] K_FIX = CW'(TRCD + TWR + TRP + 2);

  logic [CW-1:0] left_q;
  logic [CW-1:0] cost;

  always_comb begin
    cost    = K_FIX + CW'(span_w);
    expired = (left_q == '0);
    if (span_w == '0) fits = !expired;
    else              fits = (cost <= left_q);
  end

  always_ff @(posedge clk) begin
    if (rst)                  left_q <= '0;
    else if (load)            left_q <= load_val;
    else if (run && !expired) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/span_fill_seq.sv
module span_fill_seq
  import span_fill_pkg::*;
#(
  parameter int CW   = 16,
  parameter int XW   = 10,
  parameter int WW   = 11,
  parameter int ROWW = 13,
  parameter int BW   = 2,
  parameter int DW   = 16,
  parameter int MW   = 8,
  parameter int TRCD = 2,
  parameter int TWR  = 2,
  parameter int TRP  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [XW-1:0]        x,
  input  logic [ROWW+BW-1:0]   line,
  input  logic [WW-1:0]        width,
  input  logic [DW-1:0]        color,
  input  logic [MW-1:0]        skip,
  output logic                 busy,
  output logic [2:0]           cmd,
  output logic [ROWW-1:0]      addr,
  output logic [BW-1:0]        bank,
  output logic                 dqm,
  output logic [DW-1:0]        dq,
  output logic                 dq_oe
);
  localparam int MIW = (MW > 1) ? $clog2(MW) : 1;
  localparam logic [CW-1:0] K_RCD = CW'(TRCD);
  localparam logic [CW-1:0] K_WR  = CW'(TWR);
  localparam logic [CW-1:0] K_RP  = CW'(TRP);

  logic [CW-1:0]  t_q;
  logic [WW-1:0]  w_q;
  logic [XW-1:0]  x_q;
  logic [DW-1:0]  col_q;
  logic [MW-1:0]  skip_q;
  logic [CW-1:0]  t_bst, t_pre, t_last;
  logic [MIW-1:0] pix;

  always_comb begin
    t_bst  = K_RCD + CW'(w_q);
    t_pre  = t_bst + K_WR;
    t_last = t_pre + K_RP + CW'(1);
    pix    = MIW'(t_q - K_RCD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      t_q    <= '0;
      w_q    <= '0;
      x_q    <= '0;
      col_q  <= '0;
      skip_q <= '0;
      cmd    <= CMD_NOP;
      addr   <= '0;
      bank   <= '0;
      dqm    <= 1'b0;
      dq     <= '0;
      dq_oe  <= 1'b0;
    end else begin
      cmd   <= CMD_NOP;
      dq_oe <= 1'b0;
      dqm   <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        t_q    <= CW'(1);
        w_q    <= width;
        x_q    <= x;
        col_q  <= color;
        skip_q <= skip;
        cmd    <= CMD_ACT;
        addr   <= line[ROWW-1:0];
        bank   <= line[ROWW+BW-1:ROWW];
      end else if (busy) begin
        t_q <= t_q + 1'b1;
        if (t_q == t_last) busy <= 1'b0;
        if (t_q == K_RCD) begin
          cmd   <= CMD_WRITE;
          addr  <= ROWW'(x_q);
          dq    <= col_q;
          dq_oe <= 1'b1;
          dqm   <= skip_q[0];
        end else if (t_q > K_RCD && t_q < t_bst) begin
          dq_oe <= 1'b1;
          dqm   <= skip_q[pix];
        end else if (t_q == t_bst) begin
          cmd <= CMD_BST;
        end else if (t_q == t_pre) begin
          cmd  <= CMD_PRE;
          addr <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/span_fill_writer.sv
module span_fill_writer
  import span_fill_pkg::*;
#(
  parameter int XW   = 10,
  parameter int YW   = 9,
  parameter int ROWW = 13,
  parameter int BW   = 2,
  parameter int DW   = 16,
  parameter int MW   = 8,
  parameter int CW   = 16,
  parameter int TRCD = 2,
  parameter int TWR  = 2,
  parameter int TRP  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                win_grant,
  input  logic [CW-1:0]       win_clocks,
  output logic                win_done,
  input  logic [ROWW+BW-1:0]  page_base,
  input  logic                rec_valid,
  output logic                rec_ready,
  input  logic [XW-1:0]       rec_x,
  input  logic [YW-1:0]       rec_y,
  input  logic [XW:0]         rec_width,
  input  logic [DW-1:0]       rec_color,
  input  logic [MW-1:0]       rec_skip,
  output logic [2:0]          sd_cmd,
  output logic [ROWW-1:0]     sd_addr,
  output logic [BW-1:0]       sd_bank,
  output logic                sd_dqm,
  output logic [DW-1:0]       sd_dq,
  output logic                sd_dq_oe
);
  localparam int LW = ROWW + BW;
  localparam int WW = XW + 1;

  win_state_e    st_q;
  logic          busy, fits, expired, load, take, start;
  logic [LW-1:0] line;

  assign line      = page_base + LW'(rec_y);
  assign load      = (st_q == WS_OFF) && win_grant;
  assign rec_ready = (st_q == WS_OPEN) && win_grant && !busy && fits;
  assign take      = rec_ready && rec_valid;
  assign start     = take && (rec_width != '0);
  assign win_done  = (st_q == WS_DONE);

  span_fill_budget #(
    .CW(CW), .WW(WW), .TRCD(TRCD), .TWR(TWR), .TRP(TRP)
  ) budget_i (
    .clk(clk), .rst(rst), .load(load), .load_val(win_clocks),
    .run(st_q != WS_OFF), .span_w(rec_width),
    .fits(fits), .expired(expired)
  );

  span_fill_seq #(
    .CW(CW), .XW(XW), .WW(WW), .ROWW(ROWW), .BW(BW), .DW(DW), .MW(MW),
    .TRCD(TRCD), .TWR(TWR), .TRP(TRP)
  ) seq_i (
    .clk(clk), .rst(rst), .start(start), .x(rec_x), .line(line),
    .width(rec_width), .color(rec_color), .skip(rec_skip), .busy(busy),
    .cmd(sd_cmd), .addr(sd_addr), .bank(sd_bank), .dqm(sd_dqm),
    .dq(sd_dq), .dq_oe(sd_dq_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= WS_OFF;
    end else begin
      unique case (st_q)
        WS_OFF:   if (win_grant) st_q <= WS_OPEN;
        WS_OPEN:
          if (!busy) begin
            if (!win_grant)              st_q <= WS_OFF;
            else if (expired)            st_q <= WS_DONE;
            else if (rec_valid && !fits) st_q <= WS_DRAIN;
          end
        WS_DRAIN:
          if (!win_grant)   st_q <= WS_OFF;
          else if (expired) st_q <= WS_DONE;
        WS_DONE:  if (!win_grant) st_q <= WS_OFF;
        default:  st_q <= WS_OFF;
      endcase
    end
  end
endmodule

// File: rtl/span_fill_chk.sv
module span_fill_chk
  import span_fill_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          win_grant,
  input logic          win_done,
  input logic          rec_ready,
  input logic [2:0]    sd_cmd,
  input logic [DW-1:0] sd_dq,
  input logic          sd_dq_oe
);
  AST_READY_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    !win_grant |-> !rec_ready); // R1
  AST_BURST_OPENS_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(sd_dq_oe) |-> sd_cmd == CMD_WRITE); // R2
  AST_COLOR_HELD: assert property (@(posedge clk) disable iff (rst)
    sd_dq_oe |=> (!sd_dq_oe || $stable(sd_dq))); // R3
  AST_TERM_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
    sd_cmd == CMD_BST |-> !sd_dq_oe && $past(sd_dq_oe)); // R3
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    win_done |-> sd_cmd == CMD_NOP && !rec_ready && !sd_dq_oe); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    win_done && win_grant |=> win_done); // R8
endmodule

bind span_fill_writer span_fill_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .win_grant(win_grant), .win_done(win_done),
  .rec_ready(rec_ready), .sd_cmd(sd_cmd), .sd_dq(sd_dq), .sd_dq_oe(sd_dq_oe)
);

// File: tb/span_fill_writer_tb.sv
module span_fill_writer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XW = 10, YW = 9, ROWW = 13, BW = 2, DW = 16, MW = 8, CW = 16;
  localparam int TRCD = 2, TWR = 2, TRP = 2;
  localparam int LW = ROWW + BW;
  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_WR = 3'b100,
                         C_BST = 3'b110, C_PRE = 3'b010;

  logic clk = 1'b0, rst = 1'b1;
  logic win_grant = 1'b0, win_done;
  logic [CW-1:0] win_clocks = '0;
  logic [LW-1:0] page_base = '0;
  logic rec_valid = 1'b0, rec_ready;
  logic [XW-1:0] rec_x = '0;
  logic [YW-1:0] rec_y = '0;
  logic [XW:0] rec_width = '0;
  logic [DW-1:0] rec_color = '0;
  logic [MW-1:0] rec_skip = '0;
  logic [2:0] sd_cmd;
  logic [ROWW-1:0] sd_addr;
  logic [BW-1:0] sd_bank;
  logic sd_dqm, sd_dq_oe;
  logic [DW-1:0] sd_dq;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  span_fill_writer #(
    .XW(XW), .YW(YW), .ROWW(ROWW), .BW(BW), .DW(DW), .MW(MW), .CW(CW),
    .TRCD(TRCD), .TWR(TWR), .TRP(TRP)
  ) dut_i (
    .clk(clk), .rst(rst), .win_grant(win_grant), .win_clocks(win_clocks),
    .win_done(win_done), .page_base(page_base), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_x(rec_x), .rec_y(rec_y), .rec_width(rec_width),
    .rec_color(rec_color), .rec_skip(rec_skip), .sd_cmd(sd_cmd),
    .sd_addr(sd_addr), .sd_bank(sd_bank), .sd_dqm(sd_dqm), .sd_dq(sd_dq),
    .sd_dq_oe(sd_dq_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // opens a window at a falling edge; returns the count of the load edge
  task automatic open_window(input int w, output int g);
    win_clocks = CW'(w);
    win_grant = 1'b1;
    @(posedge clk);
    @(negedge clk);
    g = cyc;
  endtask

  task automatic wait_done(input int g, input int w, input string tag);
    while (!win_done && cyc < g + w + 20) @(negedge clk);
    chk(win_done && cyc == g + w + 1, tag, cyc - g, w + 1);
  endtask

  // called at a falling edge; checks the whole span schedule
  task automatic span(input int x, input int y, input int w, input logic [DW-1:0] col,
                      input logic [MW-1:0] sk, input bit chain, input string tag);
    int cost = TRCD + w + TWR + TRP + 2;
    logic [LW-1:0] ln = page_base + LW'(y);
    rec_x = XW'(x); rec_y = YW'(y); rec_width = (XW+1)'(w);
    rec_color = col; rec_skip = sk; rec_valid = 1'b1;
    #1;
    chk(rec_ready == 1'b1, {tag, " R7 span accepted within budget"}, rec_ready, 1);
    @(posedge clk);
    for (int k = 0; k < cost; k++) begin
      logic [2:0] ec;
      bit eoe;
      @(negedge clk);
      ec = C_NOP;
      if (k == 0) ec = C_ACT;
      else if (k == TRCD) ec = C_WR;
      else if (k == TRCD + w) ec = C_BST;
      else if (k == TRCD + w + TWR) ec = C_PRE;
      eoe = (k >= TRCD) && (k < TRCD + w);
      chk(sd_cmd == ec, {tag, " R2 command schedule"}, sd_cmd, ec);
      chk(sd_dq_oe == eoe, {tag, " R3 data enable window"}, sd_dq_oe, eoe);
      if (eoe) begin
        chk(sd_dq == col, {tag, " R3 colour held"}, sd_dq, col);
        chk(sd_dqm == sk[(k - TRCD) % MW], {tag, " R4 pixel mask"}, sd_dqm, sk[(k - TRCD) % MW]);
      end
      if (k == 0) begin
        chk(sd_addr == ln[ROWW-1:0], {tag, " R2 row address"}, sd_addr, ln[ROWW-1:0]);
        chk(sd_bank == ln[LW-1:ROWW], {tag, " R2 bank"}, sd_bank, ln[LW-1:ROWW]);
      end
      if (k == TRCD) begin
        chk(sd_addr == ROWW'(x), {tag, " R2 column address"}, sd_addr, x);
        chk(sd_bank == ln[LW-1:ROWW], {tag, " R2 write bank"}, sd_bank, ln[LW-1:ROWW]);
      end
      if (k < cost - 1) chk(rec_ready == 1'b0, {tag, " R9 busy during span"}, rec_ready, 0);
      else if (chain) chk(rec_ready == 1'b1, {tag, " R9 next record at cost"}, rec_ready, 1);
    end
    rec_valid = 1'b0;
  endtask

  task automatic t_reset;
    rec_valid = 1'b1; rec_width = 11'd4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rec_ready == 1'b0, "R10 ready low in reset", rec_ready, 0);
    chk(win_done == 1'b0, "R10 done low in reset", win_done, 0);
    chk(sd_cmd == C_NOP, "R10 NOP in reset", sd_cmd, C_NOP);
    chk(sd_dq_oe == 1'b0, "R10 data disabled in reset", sd_dq_oe, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(rec_ready == 1'b0, "R1 ready low without grant", rec_ready, 0);
    rec_valid = 1'b0;
  endtask

  task automatic t_main;
    int g;
    page_base = 15'd100;
    open_window(3000, g);
    span(5, 3, 6, 16'hA5C3, 8'b0110_0101, 1'b1, "basic");
    span(17, 40, 1, 16'h1234, 8'b1111_1110, 1'b1, "R5 single pixel");
    page_base = 15'd8190;
    span(1000, 5, 20, 16'hBEEF, 8'b1001_0011, 1'b1, "R4 mask wrap bank edge");
    // zero-width record
    rec_width = '0; rec_valid = 1'b1;
    #1;
    chk(rec_ready == 1'b1, "R6 zero width offered", rec_ready, 1);
    @(posedge clk);
    rec_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(sd_cmd == C_NOP && !sd_dq_oe, "R6 zero width no command", sd_cmd, C_NOP);
    end
    rec_width = 11'd3; rec_valid = 1'b1;
    #1;
    chk(rec_ready == 1'b1, "R6 ready after zero width", rec_ready, 1);
    rec_valid = 1'b0;
    wait_done(g, 3000, "R8 done after long window");
    win_grant = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_exact_fit;
    int g;
    page_base = '0;
    open_window(20, g);
    span(7, 9, 12, 16'h0F0F, 8'h00, 1'b0, "R7 cost equals budget");
    wait_done(g, 20, "R8 done at budget end");
    win_grant = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_refuse;
    int g;
    open_window(20, g);
    rec_width = 11'd13; rec_valid = 1'b1;
    #1;
    chk(rec_ready == 1'b0, "R7 one pixel too many refused", rec_ready, 0);
    @(negedge clk);
    @(negedge clk);
    rec_width = '0;
    #1;
    chk(rec_ready == 1'b0, "R8 no record after refusal", rec_ready, 0);
    wait_done(g, 20, "R8 done after refusal");
    chk(sd_cmd == C_NOP, "R8 quiet while done", sd_cmd, C_NOP);
    @(negedge clk);
    chk(win_done == 1'b1, "R8 done held under grant", win_done, 1);
    rec_valid = 1'b0;
    win_grant = 1'b0;
    @(negedge clk);
    chk(win_done == 1'b0, "R8 done clears with grant", win_done, 0);
    rec_width = '0; rec_valid = 1'b1;
    #1;
    chk(rec_ready == 1'b0, "R1 ready low after grant falls", rec_ready, 0);
    rec_valid = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_main();
    t_exact_fit();
    t_refuse();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule